// File: doc/BRIEF.md
# Ownership Record Table for Hybrid Transactions

This block holds a small hashed table of ownership records shared by software and hardware transactions. Software transactions send requests to take a record for reading, take it for writing, give it back, or to announce that a software transaction starts or ends. Each record is free, shared by a counted group of readers, or held by one writer. Hardware transactions do not take records. Before each access they send a probe that reports whether the record would conflict with that access.

A global count of live software transactions lets probes skip the table. When the count is zero, no software transaction can own anything, so the probe reports no conflict and flags that it bypassed the table. Object addresses are reduced to a record index by folding every address bit, with XOR, onto the index bit given by its position modulo the index width. Different addresses can therefore alias to the same record.

The request side is a valid/ready stream with a one-deep response stage. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting or the waiting response is being taken that cycle. The response appears on the cycle after acceptance. It stays unchanged while `rsp_ready` is low. The probe port has no handshake: its result is registered and appears on the cycle after `chk_valid`.

Top module: `orec_table`

## Requirements
- R1: After reset every record is free, the software count `sw_count` is 0, and both `rsp_valid` and `chk_done` are low.
- R2: The record index has 4 bits for 16 records. Bit k of the index is the XOR of all address bits i with i mod 4 = k. Addresses 0x12 and 0x300 therefore share record 3.
- R3: Acquire-read (op 0) behaves as follows:
  - On a free record it is granted, and the record becomes read-owned with one reader.
  - On a read-owned record it is granted and adds one reader, unless the record already has 15 readers; then it is denied.
  - On a write-owned record it is granted without change if the id is the writer's, and denied otherwise.
- R4: Acquire-write (op 1) behaves as follows:
  - On a free record it is granted, and the record becomes write-owned by the id.
  - On a write-owned record it is granted only to the owner.
  - On a read-owned record it is granted as an upgrade only if the id took the record alone from free and no other reader has joined since. Otherwise it is denied.
- R5: Release (op 2) behaves as follows:
  - On a read-owned record it is granted and removes one reader; the record becomes free when the last reader leaves.
  - On a write-owned record it is granted only to the owner, and the record becomes free.
  - On a free record it is denied.
- R6: A probe with `chk_write` low reports a conflict only if the record is write-owned. A probe with `chk_write` high reports a conflict if the record has any owner, including readers.
- R7: While `sw_count` is 0, every probe reports `chk_conflict` low and `chk_bypass` high. Otherwise `chk_bypass` is low.
- R8: Transaction-begin (op 3) increments `sw_count` and is denied at 15. Transaction-end (op 4) decrements it and is denied at 0.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. The response to an accepted request is valid on the next cycle and holds its grant while `rsp_ready` is low.
- R10: The probe result appears one cycle after `chk_valid`. It reflects the table and count as they were before any request accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code: 0 acquire-read, 1 acquire-write, 2 release, 3 transaction-begin, 4 transaction-end |
| req_addr | input | ADDR_W (32) | Object address |
| req_id | input | ID_W (4) | Software transaction id |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_grant | output | 1 | 1 = granted, 0 = denied |
| chk_valid | input | 1 | Hardware probe present |
| chk_write | input | 1 | Probe is for a write access |
| chk_addr | input | ADDR_W (32) | Probe address |
| chk_done | output | 1 | Probe result valid |
| chk_conflict | output | 1 | Probe found a conflict |
| chk_bypass | output | 1 | Probe skipped the table (no software transactions) |
| sw_count | output | SWC_W (4) | Live software transaction count |

## Verification
A software request and a hardware probe can hit the same record in the same cycle. A transaction-end that brings the count to zero can also coincide with a probe. The bench provokes both cases by driving a request and a probe together. It expects the probe to report the state from before the request: a probe that coincides with an acquire-write on a free record sees no conflict, and a probe issued on the next cycle does see one. The bench's behavioural model computes each probe result from its own record state before it applies the request. It compares responses and probe results on every clock, including across long random runs in which aliasing addresses and back-pressure are mixed.

// File: rtl/orec_pkg.sv
package orec_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } mode_e;

  localparam logic [2:0] OP_ACQ_RD   = 3'd0;
  localparam logic [2:0] OP_ACQ_WR   = 3'd1;
  localparam logic [2:0] OP_REL      = 3'd2;
  localparam logic [2:0] OP_TX_BEGIN = 3'd3;
  localparam logic [2:0] OP_TX_END   = 3'd4;
endpackage

// File: rtl/orec_hash.sv
module orec_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  // Fold every address bit onto index bit (position mod IDX_W).
  always_comb begin
    idx = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      idx[i % IDX_W] = idx[i % IDX_W] ^ addr[i];
    end
  end
endmodule

// File: rtl/orec_decide.sv
module orec_decide
  import orec_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int ID_W  = 4
) (
  input  logic [2:0]       op,
  input  logic [ID_W-1:0]  id,
  input  mode_e            cur_mode,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [ID_W-1:0]  cur_own,
  input  logic             cur_sole,
  output logic             grant,
  output mode_e            nxt_mode,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [ID_W-1:0]  nxt_own,
  output logic             nxt_sole
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};

  logic is_owner;
  assign is_owner = (cur_own == id);

  always_comb begin
    grant    = 1'b0;
    nxt_mode = cur_mode;
    nxt_cnt  = cur_cnt;
    nxt_own  = cur_own;
    nxt_sole = cur_sole;
    unique case (op)
      OP_ACQ_RD: begin
        unique case (cur_mode)
          MODE_FREE: begin
            grant = 1'b1; nxt_mode = MODE_READ; nxt_cnt = ONE;
            nxt_own = id; nxt_sole = 1'b1;
          end
          MODE_READ: begin
            if (cur_cnt != CMAX) begin
              grant = 1'b1; nxt_cnt = cur_cnt + ONE;
              nxt_own = id; nxt_sole = 1'b0;
            end
          end
          default: grant = is_owner;
        endcase
      end
      OP_ACQ_WR: begin
        unique case (cur_mode)
          MODE_FREE: begin
            grant = 1'b1; nxt_mode = MODE_WRITE; nxt_cnt = '0;
            nxt_own = id; nxt_sole = 1'b0;
          end
          MODE_READ: begin
            if (cur_sole && cur_cnt == ONE && is_owner) begin
              grant = 1'b1; nxt_mode = MODE_WRITE; nxt_cnt = '0;
              nxt_sole = 1'b0;
            end
          end
          default: grant = is_owner;
        endcase
      end
      OP_REL: begin
        unique case (cur_mode)
          MODE_READ: begin
            grant   = 1'b1;
            nxt_cnt = cur_cnt - ONE;
            if (cur_cnt == ONE) begin
              nxt_mode = MODE_FREE; nxt_sole = 1'b0;
            end
          end
          MODE_WRITE: begin
            if (is_owner) begin
              grant = 1'b1; nxt_mode = MODE_FREE; nxt_own = '0;
            end
          end
          default: grant = 1'b0;
        endcase
      end
      default: grant = 1'b0;
    endcase
  end
endmodule

// File: rtl/orec_swcount.sv
module orec_swcount #(
  parameter int SWC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic             inc_ok,
  output logic             dec_ok,
  output logic             is_zero,
  output logic [SWC_W-1:0] count
);
  localparam logic [SWC_W-1:0] SMAX = {SWC_W{1'b1}};
  localparam logic [SWC_W-1:0] SONE = SWC_W'(1);

  assign inc_ok  = (count != SMAX);
  assign dec_ok  = (count != '0);
  assign is_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc_req && inc_ok) begin
      count <= count + SONE;
    end else if (dec_req && dec_ok) begin
      count <= count - SONE;
    end
  end

  // R8
  sw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !dec_req && count != SMAX) |=> count == SWC_W'($past(count) + SONE));

  // R8
  sw_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !inc_req && count == '0) |=> count == '0);
endmodule

// File: rtl/orec_probe.sv
module orec_probe
  import orec_pkg::*;
(
  input  logic  is_write,
  input  mode_e mode,
  input  logic  sw_zero,
  output logic  conflict,
  output logic  bypass
);
  logic table_hit;
  always_comb begin
    if (is_write) table_hit = (mode != MODE_FREE);
    else          table_hit = (mode == MODE_WRITE);
  end
  assign bypass   = sw_zero;
  assign conflict = !sw_zero && table_hit;
endmodule

// File: rtl/orec_table.sv
module orec_table
  import orec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREC   = 16,
  parameter int CNT_W  = 4,
  parameter int ID_W   = 4,
  parameter int SWC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_grant,
  input  logic              chk_valid,
  input  logic              chk_write,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_done,
  output logic              chk_conflict,
  output logic              chk_bypass,
  output logic [SWC_W-1:0]  sw_count
);
  localparam int IDX_W = $clog2(NREC);

  mode_e            rec_mode [NREC];
  logic [CNT_W-1:0] rec_cnt  [NREC];
  logic [ID_W-1:0]  rec_own  [NREC];
  logic             rec_sole [NREC];

  logic [IDX_W-1:0] req_idx, chk_idx;
  logic             accept, is_rec_op, rec_grant, op_grant;
  logic             inc_ok, dec_ok, sw_zero;
  mode_e            nxt_mode;
  logic [CNT_W-1:0] nxt_cnt;
  logic [ID_W-1:0]  nxt_own;
  logic             nxt_sole;
  logic             pr_conflict, pr_bypass;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_rec_op = (req_op == OP_ACQ_RD) || (req_op == OP_ACQ_WR) || (req_op == OP_REL);

  orec_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_req_hash (.addr(req_addr), .idx(req_idx));
  orec_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk_hash (.addr(chk_addr), .idx(chk_idx));

  orec_decide #(.CNT_W(CNT_W), .ID_W(ID_W)) u_decide (
    .op(req_op), .id(req_id),
    .cur_mode(rec_mode[req_idx]), .cur_cnt(rec_cnt[req_idx]),
    .cur_own(rec_own[req_idx]), .cur_sole(rec_sole[req_idx]),
    .grant(rec_grant), .nxt_mode(nxt_mode), .nxt_cnt(nxt_cnt),
    .nxt_own(nxt_own), .nxt_sole(nxt_sole)
  );

  orec_swcount #(.SWC_W(SWC_W)) u_swcount (
    .clk(clk), .rst_n(rst_n),
    .inc_req(accept && req_op == OP_TX_BEGIN),
    .dec_req(accept && req_op == OP_TX_END),
    .inc_ok(inc_ok), .dec_ok(dec_ok), .is_zero(sw_zero), .count(sw_count)
  );

  orec_probe u_probe (
    .is_write(chk_write), .mode(rec_mode[chk_idx]), .sw_zero(sw_zero),
    .conflict(pr_conflict), .bypass(pr_bypass)
  );

  always_comb begin
    if (is_rec_op)                  op_grant = rec_grant;
    else if (req_op == OP_TX_BEGIN) op_grant = inc_ok;
    else if (req_op == OP_TX_END)   op_grant = dec_ok;
    else                            op_grant = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREC; i++) begin
        rec_mode[i] <= MODE_FREE;
        rec_cnt[i]  <= '0;
        rec_own[i]  <= '0;
        rec_sole[i] <= 1'b0;
      end
    end else if (accept && is_rec_op && rec_grant) begin
      rec_mode[req_idx] <= nxt_mode;
      rec_cnt[req_idx]  <= nxt_cnt;
      rec_own[req_idx]  <= nxt_own;
      rec_sole[req_idx] <= nxt_sole;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_grant <= op_grant;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_done     <= 1'b0;
      chk_conflict <= 1'b0;
      chk_bypass   <= 1'b0;
    end else begin
      chk_done     <= chk_valid;
      chk_conflict <= chk_valid && pr_conflict;
      chk_bypass   <= chk_valid && pr_bypass;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant)));

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  chk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  // R7
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && chk_bypass) |-> !chk_conflict);

  generate
    for (genvar g = 0; g < NREC; g++) begin : g_rec_chk
      // R4
      write_no_readers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_mode[g] == MODE_WRITE) |-> (rec_cnt[g] == '0));
      // R3
      read_has_readers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_mode[g] == MODE_READ) |-> (rec_cnt[g] != '0));
    end
  endgenerate
endmodule

// File: tb/test_orec_table.sv
`timescale 1ns/1ps
module test_orec_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_op = '0;
  logic [31:0] req_addr = '0, chk_addr = '0;
  logic [3:0]  req_id = '0;
  logic        chk_valid = 1'b0, chk_write = 1'b0;
  logic        req_ready, rsp_valid, rsp_grant, chk_done, chk_conflict, chk_bypass;
  logic [3:0]  sw_count;

  always #4 clk = ~clk;

  orec_table i_orec_table (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_grant(rsp_grant),
    .chk_valid(chk_valid), .chk_write(chk_write), .chk_addr(chk_addr),
    .chk_done(chk_done), .chk_conflict(chk_conflict), .chk_bypass(chk_bypass),
    .sw_count(sw_count)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  int m_mode[16], m_cnt[16], m_own[16], m_sole[16];
  int m_sw = 0;
  bit e_rv = 0, e_rg = 0, e_cd = 0, e_cc = 0, e_cb = 0;
  string rsp_tag = "R1", chk_tag = "R1", force_ctag = "";

  localparam logic [31:0] A = 32'h12, B = 32'h300, C = 32'h5;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int fold(logic [31:0] a);
    int r = 0;
    for (int i = 0; i < 32; i += 4) r = r ^ int'(a[i+:4]);
    return r;
  endfunction

  task automatic model_apply(int op, int ix, int id, output bit g);
    g = 0;
    case (op)
      0: begin
        if (m_mode[ix] == 2) g = (m_own[ix] == id);
        else if (m_mode[ix] == 1 && m_cnt[ix] == 15) g = 0;
        else begin
          g = 1;
          if (m_mode[ix] == 0) begin m_mode[ix] = 1; m_cnt[ix] = 1; m_sole[ix] = 1; end
          else begin m_cnt[ix]++; m_sole[ix] = 0; end
          m_own[ix] = id;
        end
      end
      1: begin
        if (m_mode[ix] == 0) begin
          g = 1; m_mode[ix] = 2; m_cnt[ix] = 0; m_own[ix] = id; m_sole[ix] = 0;
        end else if (m_mode[ix] == 1) begin
          if (m_sole[ix] == 1 && m_own[ix] == id) begin
            g = 1; m_mode[ix] = 2; m_cnt[ix] = 0; m_sole[ix] = 0;
          end
        end else g = (m_own[ix] == id);
      end
      2: begin
        if (m_mode[ix] == 1) begin
          g = 1; m_cnt[ix]--;
          if (m_cnt[ix] == 0) begin m_mode[ix] = 0; m_sole[ix] = 0; end
        end else if (m_mode[ix] == 2 && m_own[ix] == id) begin
          g = 1; m_mode[ix] = 0; m_own[ix] = 0;
        end
      end
      3: if (m_sw < 15) begin g = 1; m_sw++; end
      4: if (m_sw > 0) begin g = 1; m_sw--; end
      default: g = 0;
    endcase
  endtask

  function automatic string op_tag(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R8";
    endcase
  endfunction

  // one cycle: compare outputs of previous edge, drive, predict next edge
  task automatic step(bit v, int op, logic [31:0] a, int id, bit rr,
                      bit cv, bit cw, logic [31:0] ca);
    bit g, acc;
    int cix;
    check(rsp_valid == e_rv, "R9", "rsp_valid", rsp_valid, e_rv);
    if (e_rv) check(rsp_grant == e_rg, rsp_tag, "rsp_grant", rsp_grant, e_rg);
    check(chk_done == e_cd, "R10", "chk_done", chk_done, e_cd);
    if (e_cd) begin
      check(chk_conflict == e_cc, chk_tag, "chk_conflict", chk_conflict, e_cc);
      check(chk_bypass == e_cb, chk_tag, "chk_bypass", chk_bypass, e_cb);
    end
    check(int'(sw_count) == m_sw, "R8", "sw_count", sw_count, m_sw);
    req_valid = v; req_op = 3'(op); req_addr = a; req_id = 4'(id);
    rsp_ready = rr; chk_valid = cv; chk_write = cw; chk_addr = ca;
    #1;
    check(req_ready == (!e_rv || rr), "R9", "req_ready", req_ready, !e_rv || rr);
    // probe sees state before this edge's request
    cix = fold(ca);
    e_cd = cv;
    e_cb = cv && (m_sw == 0);
    e_cc = cv && (m_sw != 0) && (cw ? (m_mode[cix] != 0) : (m_mode[cix] == 2));
    chk_tag = (force_ctag != "") ? force_ctag : ((m_sw == 0) ? "R7" : "R6");
    acc = v && (!e_rv || rr);
    if (acc) begin
      model_apply(op, fold(a), id, g);
      e_rv = 1; e_rg = g; rsp_tag = op_tag(op);
    end else if (rr) e_rv = 0;
    @(negedge clk);
  endtask

  task automatic req(int op, logic [31:0] a, int id);
    step(1, op, a, id, 1, 0, 0, '0);
  endtask

  task automatic probe(bit cw, logic [31:0] ca);
    step(0, 0, '0, 0, 1, 1, cw, ca);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_mode[i] = 0; m_cnt[i] = 0; m_own[i] = 0; m_sole[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(rsp_valid == 0 && chk_done == 0, "R1", "outputs after reset", rsp_valid | chk_done, 0);
    check(sw_count == 0, "R1", "sw_count after reset", sw_count, 0);
    probe(1, A);                       // R1, R7: free table, count zero -> bypass
    probe(1, C);
    req(3, '0, 0);                     // R8 begin
    probe(1, A);                       // R6 free record, write probe
    req(0, A, 1);                      // R3 read from free
    probe(0, A);                       // R6 read probe on read-owned: no conflict
    probe(1, A);                       // R6 write probe on read-owned: conflict
    req(1, A, 1);                      // R4 upgrade by sole reader
    req(0, A, 2);                      // R3 denied: write-owned by other
    req(0, A, 1);                      // R3 granted: owner reads
    probe(0, A);                       // R6 read probe on write-owned
    req(0, B, 2);                      // R2 alias of A is write-owned -> denied
    probe(0, B);                       // R2 alias probe conflicts
    req(2, A, 2);                      // R5 release by non-owner denied
    req(2, B, 1);                      // R2, R5 release via alias by owner
    req(2, A, 1);                      // R5 free record release denied
    req(0, C, 1);                      // R3
    req(0, C, 2);                      // R3 join
    req(1, C, 1);                      // R4 upgrade denied after join
    req(2, C, 2);
    req(1, C, 1);                      // R4 still denied: joined history
    req(2, C, 1);                      // R5 last reader frees
    req(1, C, 3);                      // R4 write from free
    req(1, C, 3);                      // R4 owner re-acquire
    req(1, C, 1);                      // R4 other denied
    req(2, C, 3);                      // R5
    for (int i = 0; i < 16; i++) req(0, A, i % 16);   // R3 saturates at 15 readers
    for (int i = 0; i < 15; i++) req(2, A, 0);        // R5 drain
    // R10: request and probe together on the same record
    force_ctag = "R10";
    step(1, 1, C, 4, 1, 1, 0, C);
    probe(0, C);
    req(2, C, 4);
    // R10: transaction-end to zero together with a probe
    req(0, C, 5);
    step(1, 4, '0, 0, 1, 1, 1, C);
    probe(1, C);
    force_ctag = "";
    req(4, '0, 0);                     // R8 end at zero denied
    req(2, C, 5);
    // R9 back-pressure
    step(1, 0, A, 1, 0, 0, 0, '0);
    step(1, 2, A, 1, 0, 0, 0, '0);
    step(1, 2, A, 1, 0, 0, 0, '0);
    step(1, 2, A, 1, 1, 0, 0, '0);
    step(0, 0, '0, 0, 1, 0, 0, '0);
    // R8 saturate
    for (int i = 0; i < 16; i++) req(3, '0, 0);
    for (int i = 0; i < 16; i++) req(4, '0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] pool [5];
      pool[0] = A; pool[1] = B; pool[2] = C; pool[3] = 32'h7; pool[4] = 32'hff00;
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 4),
           pool[$urandom_range(0, 4)], $urandom_range(0, 3),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
           $urandom_range(0, 1), pool[$urandom_range(0, 4)]);
    end
    step(0, 0, '0, 0, 1, 0, 0, '0);
    step(0, 0, '0, 0, 1, 0, 0, '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule